// File: doc/BRIEF.md
# Interprocessor Interrupt Command Register

This block is the command register through which a processor sends an interrupt message to other processors. Software sees it as two 32-bit words on a simple register bus: a control word and a destination word. The destination word holds the target processor ID in its top byte. The control word holds the vector, the delivery mode, the level and trigger bits and the destination shorthand.

Writing the destination word only stores the target. Writing the control word captures its fields and launches one message on an outbound valid/ready port. A busy flag in the control word reads back as set until the receiver accepts the message. Software polls that flag before it sends again. A control-word write that arrives while a message is still pending is dropped, and a sticky error flag records the drop.

Top module: `ipi_cmd_reg`

## Requirements
- R1: After reset, both words read back as zero and `msg_valid_o` is low.
- R2: A write to the destination word (offset 0x10) launches no message. It reads back with bits 31:24 holding the written ID and all other bits zero.
- R3: A write to the control word (offset 0x00) while idle raises `msg_valid_o` from the next cycle. The payload carries vector = wdata[7:0], mode = wdata[10:8], level = wdata[14], trigger = wdata[15] and shorthand = wdata[19:18].
- R4: Control-word bit 12 (busy) reads 1 from the launch until the cycle after `msg_valid_o && msg_ready_i`, and then reads 0. It always equals `msg_valid_o`.
- R5: While `msg_valid_o` is high and `msg_ready_i` is low, the payload stays stable.
- R6: A control-word write while busy is dropped, so the payload is unchanged. It sets the error flag at control-word bit 20. That flag stays set until the next accepted control-word write clears it.
- R7: Shorthand 2'b11 (all but self) drives `msg_dest_o` to zero, whatever the destination word holds.
- R8: When the shorthand is not 2'b11, `msg_dest_o` is the destination ID as it was at launch. A destination-word write during a pending message only affects later messages.
- R9: Control-word readback returns the stored fields at the bit positions of R3, busy at bit 12 and error at bit 20. All other bits read zero. Bits 12 and 20 cannot be written.
- R10: Delivery mode codes pass unchanged into the message: fixed 3'b000, SMI 3'b010, INIT 3'b101, start-up 3'b110.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| bus_sel_i | input | 1 | register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | byte offset of the accessed word |
| bus_wdata_i | input | 32 | write data |
| bus_rdata_o | output | 32 | read data (combinational) |
| msg_valid_o | output | 1 | message pending |
| msg_ready_i | input | 1 | receiver accepts message |
| msg_vector_o | output | 8 | interrupt vector |
| msg_mode_o | output | 3 | delivery mode |
| msg_level_o | output | 1 | level bit |
| msg_trig_o | output | 1 | trigger mode bit |
| msg_short_o | output | 2 | destination shorthand |
| msg_dest_o | output | 8 | destination processor ID |

## Verification
The hardest state to reach is a pending message that receives bus traffic before it is accepted. In that state, a destination rewrite must not reach the in-flight message, and a second control write must be dropped with an error. The bench holds `msg_ready_i` low after a launch so the message stays pending. It issues both writes in that window and checks the payload and readback before it finally grants acceptance. Later launches confirm that the new destination takes effect and that the error flag clears.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int DATA_W = 32;
  localparam int VEC_W  = 8;
  localparam int MODE_W = 3;
  localparam int SH_W   = 2;
  localparam int DEST_W = 8;

  localparam int VEC_LSB  = 0;
  localparam int MODE_LSB = 8;
  localparam int BUSY_BIT = 12;
  localparam int LVL_BIT  = 14;
  localparam int TRIG_BIT = 15;
  localparam int SH_LSB   = 18;
  localparam int ERR_BIT  = 20;
  localparam int DEST_LSB = DATA_W - DEST_W;

  localparam logic [SH_W-1:0] SH_ALL_BUT_SELF = 2'b11;

  typedef struct packed {
    logic [SH_W-1:0]   sh;
    logic              trig;
    logic              lvl;
    logic [MODE_W-1:0] mode;
    logic [VEC_W-1:0]  vec;
  } ctl_t;

  function automatic ctl_t unpack_ctl(input logic [DATA_W-1:0] w);
    ctl_t c;
    c.vec  = w[VEC_LSB +: VEC_W];
    c.mode = w[MODE_LSB +: MODE_W];
    c.lvl  = w[LVL_BIT];
    c.trig = w[TRIG_BIT];
    c.sh   = w[SH_LSB +: SH_W];
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] pack_ctl(input ctl_t c, input logic busy,
                                                 input logic err);
    logic [DATA_W-1:0] w;
    w = '0;
    w[VEC_LSB +: VEC_W]   = c.vec;
    w[MODE_LSB +: MODE_W] = c.mode;
    w[BUSY_BIT]           = busy;
    w[LVL_BIT]            = c.lvl;
    w[TRIG_BIT]           = c.trig;
    w[SH_LSB +: SH_W]     = c.sh;
    w[ERR_BIT]            = err;
    return w;
  endfunction
endpackage

// File: rtl/ipi_regs.sv
module ipi_regs
  import ipi_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              wr_high_i,
  input  logic [DATA_W-1:0] wdata_i,
  output ctl_t              ctl_o,
  output logic [DEST_W-1:0] dest_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_o  <= '0;
      dest_o <= '0;
    end else begin
      if (accept_i)  ctl_o  <= unpack_ctl(wdata_i);
      if (wr_high_i) dest_o <= wdata_i[DEST_LSB +: DEST_W];
    end
  end
endmodule

// File: rtl/ipi_launch.sv
module ipi_launch
  import ipi_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_low_i,
  input  logic [SH_W-1:0]   sh_i,
  input  logic [DEST_W-1:0] dest_i,
  input  logic              ready_i,
  output logic              accept_o,
  output logic              busy_o,
  output logic              err_o,
  output logic [DEST_W-1:0] dest_o
);
  assign accept_o = wr_low_i && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      err_o  <= 1'b0;
      dest_o <= '0;
    end else begin
      if (accept_o) begin
        busy_o <= 1'b1;
        err_o  <= 1'b0;
        // shorthand broadcast carries no target
        dest_o <= (sh_i == SH_ALL_BUT_SELF) ? '0 : dest_i;
      end else begin
        if (busy_o && ready_i) busy_o <= 1'b0;
        if (wr_low_i)          err_o  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ipi_cmd_reg.sv
module ipi_cmd_reg
  import ipi_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] LOW_OFF  = 8'h00,
  parameter logic [ADDR_W-1:0] HIGH_OFF = 8'h10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              msg_valid_o,
  input  logic              msg_ready_i,
  output logic [7:0]        msg_vector_o,
  output logic [2:0]        msg_mode_o,
  output logic              msg_level_o,
  output logic              msg_trig_o,
  output logic [1:0]        msg_short_o,
  output logic [7:0]        msg_dest_o
);
  logic hit_low, hit_high, wr_low, wr_high, accept, busy, err;
  ctl_t ctl_q;
  ctl_t ctl_new;
  logic [DEST_W-1:0] dest_q;

  assign hit_low  = bus_sel_i && (bus_addr_i == LOW_OFF);
  assign hit_high = bus_sel_i && (bus_addr_i == HIGH_OFF);
  assign wr_low   = hit_low && bus_we_i;
  assign wr_high  = hit_high && bus_we_i;
  assign ctl_new  = unpack_ctl(bus_wdata_i);

  ipi_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .wr_high_i (wr_high),
    .wdata_i   (bus_wdata_i),
    .ctl_o     (ctl_q),
    .dest_o    (dest_q)
  );

  ipi_launch u_launch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_low_i (wr_low),
    .sh_i     (ctl_new.sh),
    .dest_i   (dest_q),
    .ready_i  (msg_ready_i),
    .accept_o (accept),
    .busy_o   (busy),
    .err_o    (err),
    .dest_o   (msg_dest_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (hit_low && !bus_we_i)       bus_rdata_o = pack_ctl(ctl_q, busy, err);
    else if (hit_high && !bus_we_i) bus_rdata_o[DEST_LSB +: DEST_W] = dest_q;
  end

  assign msg_valid_o  = busy;
  assign msg_vector_o = ctl_q.vec;
  assign msg_mode_o   = ctl_q.mode;
  assign msg_level_o  = ctl_q.lvl;
  assign msg_trig_o   = ctl_q.trig;
  assign msg_short_o  = ctl_q.sh;
endmodule

// File: rtl/ipi_cmd_reg_chk.sv
module ipi_cmd_reg_chk #(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] LOW_OFF  = 8'h00,
  parameter logic [ADDR_W-1:0] HIGH_OFF = 8'h10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_sel_i,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [31:0]       bus_rdata_o,
  input logic              msg_valid_o,
  input logic              msg_ready_i,
  input logic [7:0]        msg_vector_o,
  input logic [2:0]        msg_mode_o,
  input logic [1:0]        msg_short_o,
  input logic [7:0]        msg_dest_o
);
  logic lw, hw, lr;
  assign lw = bus_sel_i && bus_we_i && (bus_addr_i == LOW_OFF);
  assign hw = bus_sel_i && bus_we_i && (bus_addr_i == HIGH_OFF);
  assign lr = bus_sel_i && !bus_we_i && (bus_addr_i == LOW_OFF);

  p_high_no_launch_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!msg_valid_o && hw) |=> !msg_valid_o);
  p_launch_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!msg_valid_o && lw) |=> msg_valid_o);
  p_busy_read_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lr |-> (bus_rdata_o[12] == msg_valid_o));
  p_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && msg_ready_i && !lw) |=> !msg_valid_o);
  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && !msg_ready_i) |=> (msg_valid_o && $stable(msg_vector_o)
                                       && $stable(msg_mode_o) && $stable(msg_dest_o)));
  p_drop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && lw) |=> $stable(msg_vector_o) && $stable(msg_short_o));
  p_bcast_dest_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && msg_short_o == 2'b11) |-> (msg_dest_o == 8'h00));
endmodule

bind ipi_cmd_reg ipi_cmd_reg_chk #(
  .ADDR_W(ADDR_W), .LOW_OFF(LOW_OFF), .HIGH_OFF(HIGH_OFF)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_sel_i(bus_sel_i), .bus_we_i(bus_we_i),
  .bus_addr_i(bus_addr_i), .bus_rdata_o(bus_rdata_o), .msg_valid_o(msg_valid_o),
  .msg_ready_i(msg_ready_i), .msg_vector_o(msg_vector_o), .msg_mode_o(msg_mode_o),
  .msg_short_o(msg_short_o), .msg_dest_o(msg_dest_o)
);

// File: tb/tb_ipi_cmd_reg.sv
module tb_ipi_cmd_reg;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] LO = 8'h00;
  localparam logic [7:0] HI = 8'h10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel = 1'b0, we = 1'b0, ready = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic valid, lvl, trig;
  logic [7:0] vec, dest;
  logic [2:0] mode;
  logic [1:0] sh;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ipi_cmd_reg dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .msg_valid_o(valid), .msg_ready_i(ready),
    .msg_vector_o(vec), .msg_mode_o(mode), .msg_level_o(lvl), .msg_trig_o(trig),
    .msg_short_o(sh), .msg_dest_o(dest)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    sel = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    sel = 1'b0;
  endtask

  task automatic accept(input string req);
    @(negedge clk);
    ready = 1'b1;
    @(negedge clk);
    ready = 1'b0;
    check(req, {31'd0, valid}, 32'd0);
  endtask

  task automatic t_reset;
    logic [31:0] r;
    check("R1 valid", {31'd0, valid}, 32'd0);
    bus_rd(LO, r); check("R1 low", r, 32'd0);
    bus_rd(HI, r); check("R1 high", r, 32'd0);
  endtask

  task automatic t_high_only;
    logic [31:0] r;
    bus_wr(HI, 32'hAB00_1234);
    @(negedge clk);
    check("R2 no launch", {31'd0, valid}, 32'd0);
    bus_rd(HI, r); check("R2 readback", r, 32'hAB00_0000);
  endtask

  task automatic t_pending;
    logic [31:0] r;
    bus_wr(LO, 32'h0000_4041);
    check("R3 valid", {31'd0, valid}, 32'd1);
    check("R3 vector", {24'd0, vec}, 32'h41);
    check("R10 fixed mode", {29'd0, mode}, 32'd0);
    check("R3 level/trig/sh", {28'd0, lvl, trig, sh}, 32'h8);
    check("R8 dest", {24'd0, dest}, 32'hAB);
    bus_rd(LO, r); check("R4 busy set", r, 32'h0000_5041);
    repeat (3) @(negedge clk);
    check("R5 hold", {23'd0, valid, vec}, 32'h141);
    bus_wr(HI, 32'h5500_0000);
    check("R8 in-flight dest", {24'd0, dest}, 32'hAB);
    bus_wr(LO, 32'h0000_4099);
    check("R6 dropped", {24'd0, vec}, 32'h41);
    bus_rd(LO, r); check("R6 error set", r, 32'h0010_5041);
    accept("R4 clear");
    bus_rd(LO, r); check("R6 sticky / R4 idle", r, 32'h0010_4041);
  endtask

  task automatic t_modes;
    logic [31:0] r;
    bus_wr(LO, 32'h0000_4200);
    check("R10 SMI", {29'd0, mode}, 32'd2);
    check("R8 new dest", {24'd0, dest}, 32'h55);
    bus_rd(LO, r); check("R6 error cleared", {31'd0, r[20]}, 32'd0);
    accept("R4 clear smi");
    bus_wr(LO, 32'h0000_4500);
    check("R10 INIT", {29'd0, mode}, 32'd5);
    accept("R4 clear init");
    bus_wr(LO, 32'h0000_4608);
    check("R10 start-up", {21'd0, mode, vec}, 32'h608);
    accept("R4 clear startup");
  endtask

  task automatic t_broadcast;
    logic [31:0] r;
    bus_wr(LO, 32'hFFFF_FFFF);
    check("R7 dest zero", {24'd0, dest}, 32'd0);
    check("R7 shorthand", {30'd0, sh}, 32'd3);
    bus_rd(LO, r); check("R9 readback", r, 32'h000C_D7FF);
    accept("R4 clear bcast");
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_high_only();
    t_pending();
    t_modes();
    t_broadcast();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule